// File: doc/BRIEF.md
# Fixed-Latency Bus Ready Generator

This block is the completion logic of an APB slave whose peripheral always needs the same number of cycles to finish an access. It follows the select and enable inputs, counts the cycles of each ACCESS phase, and holds the ready output low until a parameterised number of wait cycles has passed. It then raises ready for the one cycle that closes the transfer. On that cycle it also pulses a write-commit strobe for writes or a read-valid strobe for reads. Read data from the peripheral is captured on the last wait cycle, so the value returned on the closing cycle does not change even if the peripheral's output moves.

When the slave is not selected, ready is held high, so an idle slave can never stall a transfer on a shared ready line. A latency of zero gives a slave that is always ready: every access finishes in its first ACCESS cycle and read data passes straight through.

Top module: `fixlat_ready_gen`

## Requirements
- R1: With WAIT_CYCLES = N, each access sees exactly N ACCESS-phase cycles (select = 1, enable = 1) with `pready` = 0, and `pready` = 1 on the cycle after those N.
- R2: Whenever `psel` = 0, `pready` = 1 and both strobes are 0, whatever the value of `penable`.
- R3: `pready` is high for only one ACCESS cycle per access. In the SETUP cycle that follows a completion, `pready` is 0 (when N > 0).
- R4: `wr_commit` = 1 only on the completing cycle of an access with `pwrite` = 1, and is 0 on every wait cycle.
- R5: `rd_valid` = 1 only on the completing cycle of an access with `pwrite` = 0, and is 0 on every wait cycle.
- R6: For N ≥ 1, `prdata` on the completing cycle equals the value `periph_rdata` had during the last wait cycle, even if `periph_rdata` changes on the completing cycle.
- R7: With N = 0, `pready` = 1 on the first ACCESS cycle, the matching strobe fires on that cycle, and `prdata` equals `periph_rdata` on that cycle.
- R8: If `psel` drops in the middle of the wait cycles, the count is cleared, and the next access waits the full N cycles.
- R9: Back-to-back accesses (a SETUP cycle right after a completion) each wait exactly N cycles.
- R10: After the active-low asynchronous reset `rst_n`, including a reset asserted in the middle of a wait, `pready` = 1 while `psel` = 0, both strobes are 0, and the next access waits the full N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Second-phase (ACCESS) indicator |
| pwrite | input | 1 | 1 = write access, 0 = read access |
| periph_rdata | input | DATA_W | Read data from the peripheral |
| pready | output | 1 | Transfer completion to the bus |
| prdata | output | DATA_W | Read data returned to the bus |
| wr_commit | output | 1 | One-cycle pulse to commit a write |
| rd_valid | output | 1 | One-cycle pulse marking valid read data |

## Verification
The read-data capture and the completion strobe can fall on adjacent edges, and with a zero latency they fall in the same cycle. The bench provokes the adjacent case on every read: it drives a distinct marker on `periph_rdata` only during the final wait cycle, then replaces it on the completing cycle. The read passes only if `rd_valid` and `prdata` together show the marker. A second instance with zero latency shares the bus. On its single ACCESS cycle the bench checks that ready, the strobe and pass-through data all appear together.

// File: rtl/fw_pkg.sv
package fw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } bus_phase_e;

    function automatic bus_phase_e classify_phase(input logic sel, input logic en);
        if (!sel)
            return PH_IDLE;
        else if (!en)
            return PH_SETUP;
        else
            return PH_ACCESS;
    endfunction

endpackage

// File: rtl/fw_wait_counter.sv
module fw_wait_counter #(
    parameter int WAIT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic terminal,
    output logic last_wait
);
    import fw_pkg::*;

    localparam int CW = (WAIT_CYCLES < 1) ? 1 : $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] TERM = CW'(WAIT_CYCLES);
    localparam logic [CW-1:0] PRE  = (WAIT_CYCLES > 0) ? CW'(WAIT_CYCLES - 1) : '0;
    localparam bit HAS_WAIT = (WAIT_CYCLES > 0);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t       st_d, st_q;
    bus_phase_e phase;

    always_comb begin
        phase     = classify_phase(psel, penable);
        terminal  = (phase == PH_ACCESS) && (st_q.cnt == TERM);
        last_wait = HAS_WAIT && (phase == PH_ACCESS) && (st_q.cnt == PRE);
        st_d      = st_q;
        case (phase)
            PH_ACCESS: st_d.cnt = terminal ? '0 : st_q.cnt + 1'b1;
            default:   st_d.cnt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R1: the count never runs past the terminal value
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TERM);

    // R3: a completion leaves the counter reloaded for the next access
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        terminal |=> (st_q.cnt == '0));

    // R8: a dropped select leaves no stale count
    a_r8_abort_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !psel |=> (st_q.cnt == '0));

endmodule

// File: rtl/fw_rdata_hold.sv
module fw_rdata_hold #(
    parameter int WAIT_CYCLES = 3,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [DATA_W-1:0] rdata_out
);

    generate
        if (WAIT_CYCLES == 0) begin : g_pass
            assign rdata_out = rdata_in;
        end else begin : g_hold
            typedef struct packed {
                logic [DATA_W-1:0] data;
            } hold_t;

            hold_t hd_d, hd_q;

            always_comb begin
                hd_d = hd_q;
                if (cap_en)
                    hd_d.data = rdata_in;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    hd_q <= '0;
                else
                    hd_q <= hd_d;
            end

            assign rdata_out = hd_q.data;

            // R6: between captures the returned data does not move
            a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
                !cap_en |=> $stable(hd_q.data));
        end
    endgenerate

endmodule

// File: rtl/fixlat_ready_gen.sv
module fixlat_ready_gen #(
    parameter int WAIT_CYCLES = 3,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [DATA_W-1:0] periph_rdata,
    output logic              pready,
    output logic [DATA_W-1:0] prdata,
    output logic              wr_commit,
    output logic              rd_valid
);

    logic terminal;
    logic last_wait;

    fw_wait_counter #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .terminal  (terminal),
        .last_wait (last_wait)
    );

    fw_rdata_hold #(
        .WAIT_CYCLES (WAIT_CYCLES),
        .DATA_W      (DATA_W)
    ) u_rdata (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (last_wait),
        .rdata_in  (periph_rdata),
        .rdata_out (prdata)
    );

    always_comb begin
        pready    = !psel || terminal;
        wr_commit = terminal && pwrite;
        rd_valid  = terminal && !pwrite;
    end

    // R2: an unselected slave never pulls ready low
    a_r2_unsel_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !psel |-> (pready && !wr_commit && !rd_valid));

    // R4: a write commit is a single-cycle pulse
    a_r4_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R5: read-valid is a single-cycle pulse
    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: tb/fixlat_ready_gen_bench.sv
module fixlat_ready_gen_bench;

    localparam int CLK_P  = 10;
    localparam int N_MAIN = 3;
    localparam int DW     = 32;

    typedef struct packed {
        logic          wr;
        logic [DW-1:0] dat;
        logic [3:0]    gap;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'hA5A5_0001, 4'd2},
        '{1'b1, 32'h0000_0002, 4'd1},
        '{1'b0, 32'h1234_5678, 4'd0},
        '{1'b0, 32'hCAFE_F00D, 4'd0},
        '{1'b1, 32'h0000_0005, 4'd0},
        '{1'b0, 32'h0F0F_0F0F, 4'd3},
        '{1'b1, 32'h0000_0007, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          penable_z = 1'b0;
    logic          pwrite = 1'b0;
    logic [DW-1:0] periph_rdata = '0;

    logic          pready, wr_commit, rd_valid;
    logic [DW-1:0] prdata;
    logic          pready_z, wr_commit_z, rd_valid_z;
    logic [DW-1:0] prdata_z;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    fixlat_ready_gen #(.WAIT_CYCLES(N_MAIN), .DATA_W(DW)) u_fixlat_ready_gen (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .periph_rdata(periph_rdata), .pready(pready), .prdata(prdata),
        .wr_commit(wr_commit), .rd_valid(rd_valid)
    );

    fixlat_ready_gen #(.WAIT_CYCLES(0), .DATA_W(DW)) u_fixlat_ready_gen_zero (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable_z), .pwrite(pwrite),
        .periph_rdata(periph_rdata), .pready(pready_z), .prdata(prdata_z),
        .wr_commit(wr_commit_z), .rd_valid(rd_valid_z)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access on the shared bus; returns in the middle of the completing cycle.
    task automatic run_access(input logic wr, input logic [DW-1:0] dat, input int gap,
                              input string tag);
        int waits;
        bit done;
        if (gap > 0) begin
            @(negedge clk);
            psel = 1'b0; penable = 1'b0; penable_z = 1'b0;
            #1;
            chk(pready === 1'b1, {"R2 idle ready ", tag}, DW'(pready), 1);
            repeat (gap - 1) @(negedge clk);
        end
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; penable_z = 1'b0; pwrite = wr;
        periph_rdata = 32'hBAD0_0000;
        #1;
        if (gap == 0)
            chk(pready === 1'b0, {"R3 no ready in setup after completion ", tag}, DW'(pready), 0);
        @(negedge clk);
        penable = 1'b1; penable_z = 1'b1;
        waits = 0;
        done = 1'b0;
        while (!done) begin
            if (waits == N_MAIN)          periph_rdata = ~dat;
            else if (waits == N_MAIN - 1) periph_rdata = dat;
            else                          periph_rdata = 32'hBAD0_0000 | DW'(waits);
            #1;
            if (waits == 0) begin
                chk(pready_z === 1'b1, {"R7 zero-latency ready ", tag}, DW'(pready_z), 1);
                chk(wr_commit_z === wr && rd_valid_z === !wr,
                    {"R7 zero-latency strobe ", tag}, {wr_commit_z, rd_valid_z}, {wr, !wr});
                chk(prdata_z === periph_rdata, {"R7 zero-latency data ", tag}, prdata_z, periph_rdata);
                penable_z = 1'b0;
            end
            if (pready === 1'b1) begin
                done = 1'b1;
            end else begin
                if (wr_commit !== 1'b0 || rd_valid !== 1'b0)
                    chk(1'b0, {"R4 R5 strobe during wait ", tag}, {wr_commit, rd_valid}, 0);
                waits++;
                if (waits > N_MAIN + 4) begin
                    chk(1'b0, {"R1 ready never rose ", tag}, DW'(waits), DW'(N_MAIN));
                    done = 1'b1;
                end else begin
                    @(negedge clk);
                end
            end
        end
        chk(waits == N_MAIN, {"R1 R9 wait length ", tag}, DW'(waits), DW'(N_MAIN));
        chk(wr_commit === wr, {"R4 commit on completion ", tag}, DW'(wr_commit), DW'(wr));
        chk(rd_valid === !wr, {"R5 valid on completion ", tag}, DW'(rd_valid), DW'(!wr));
        if (!wr)
            chk(prdata === dat, {"R6 captured read data ", tag}, prdata, dat);
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(pready === 1'b1 && wr_commit === 1'b0 && rd_valid === 1'b0,
            "R10 reset state", {pready, wr_commit, rd_valid}, 3'b100);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table: R1 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++)
            run_access(VECS[i].wr, VECS[i].dat, int'(VECS[i].gap), $sformatf("vec%0d", i));

        // R2: unselected with enable high
        @(negedge clk);
        psel = 1'b0; penable = 1'b1; penable_z = 1'b1;
        #1;
        chk(pready === 1'b1 && wr_commit === 1'b0 && rd_valid === 1'b0,
            "R2 unselected with enable high", {pready, wr_commit, rd_valid}, 3'b100);
        @(negedge clk);
        penable = 1'b0; penable_z = 1'b0;

        // R8: abort during the wait cycles
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #1;
        chk(pready === 1'b1, "R8 ready after abort", DW'(pready), 1);
        run_access(1'b0, 32'h5EED_0008, 1, "R8 after abort");

        // R10: reset in the middle of a wait
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        rst_n = 1'b0; psel = 1'b0; penable = 1'b0;
        #1;
        chk(pready === 1'b1 && wr_commit === 1'b0 && rd_valid === 1'b0,
            "R10 reset mid-wait", {pready, wr_commit, rd_valid}, 3'b100);
        @(negedge clk);
        rst_n = 1'b1;
        run_access(1'b1, 32'h0000_000A, 1, "R10 after reset");

        @(negedge clk);
        psel = 1'b0; penable = 1'b0; penable_z = 1'b0;
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule